// File: doc/BRIEF.md
# Flash Program/Erase Write-Protect Arbiter

This block decides whether a program or erase request aimed at a flash array may go ahead. The array is split into equal blocks, and each block has a software lock bit. Two active-low protection pins add hardware protection on top of those bits. The boot pin guards only the highest block. The general write-protect pin guards every other block. A pin and a lock bit act as an OR, so the block is protected when either one says so. Software can still read back the lock bits it stored, even while a pin is overriding them.

A start strobe presents the target address. The block samples the pin levels and lock bits present at that strobe and computes the verdict. One cycle later it gives exactly one of two one-cycle pulses: a start pulse for the program/erase engine or a reject pulse. It also holds a steady allow flag for the operation until the next strobe. If a lock write happens in the same cycle as a strobe, the decision uses the lock values from before that write.

Top module: `wprot_arbiter`

## Requirements
- R1: After reset every lock bit reads back 1 (locked), `op_allowed` is 0, and neither `eng_start` nor `op_reject` is high.
- R2: When `lock_we` is high at a clock edge, the lock bit selected by `lock_wsel` takes `lock_wdata`. `lock_rdata` combinationally shows the stored bit selected by `lock_rsel`.
- R3: The target block is `req_addr[19:16]`, which gives 16 blocks of 64 KByte each. Block 15 (addresses 0xF0000 to 0xFFFFF) is the boot block.
- R4: When `boot_lock_n` is 0 at the strobe, a request to block 15 is rejected, whatever its lock bit holds.
- R5: When `boot_lock_n` is 1 at the strobe, a request to block 15 is granted exactly when its lock bit is 0.
- R6: When `wr_prot_n` is 0 at the strobe, a request to any block 0 to 14 is rejected. When `wr_prot_n` is 1, such a request is granted exactly when that block's lock bit is 0.
- R7: The two pins act independently. `boot_lock_n` has no effect on blocks 0 to 14, and `wr_prot_n` has no effect on block 15.
- R8: Writing 0 to a lock bit while its pin is low makes that bit read back 0, but requests to the block are still rejected.
- R9: One cycle after a `req_start` strobe, exactly one of `eng_start` and `op_reject` is high, and only for that one cycle. Neither pulse occurs without a strobe.
- R10: `op_allowed` is updated only by a strobe, to 1 for a grant and 0 for a reject. Changes to the pins or lock bits after the strobe leave it unchanged.
- R11: A lock write in the same cycle as a strobe does not affect that strobe's decision. It does apply to later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_lock_n | input | 1 | Active-low hardware protection of the boot block |
| wr_prot_n | input | 1 | Active-low hardware protection of all other blocks |
| lock_we | input | 1 | Lock bit write enable |
| lock_wsel | input | 4 | Block whose lock bit is written |
| lock_wdata | input | 1 | New lock bit value (1 = locked) |
| lock_rsel | input | 4 | Block whose lock bit is read |
| lock_rdata | output | 1 | Stored lock bit of the block selected by lock_rsel |
| req_start | input | 1 | Program/erase start strobe |
| req_addr | input | 20 | Target byte address of the operation |
| eng_start | output | 1 | One-cycle start pulse to the program/erase engine |
| op_reject | output | 1 | One-cycle pulse for a denied request |
| op_allowed | output | 1 | Latched allow flag of the latest operation |

## Verification
The assertions check the following on every cycle:
- the grant and reject pulses never overlap, and each one follows a strobe;
- every strobe produces a verdict;
- a pin that is low at the strobe forces a reject for the blocks it covers;
- the allow flag stays unchanged between strobes;
- a written lock bit shows up on the read port.

Some behaviour depends on sequences of events, so only the bench scenarios can show it:
- a lock bit that reads back as cleared but stays overridden by its pin;
- the exact block boundary at 0xF0000;
- the pin independence;
- a lock write that coincides with a strobe.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   typedef enum logic [1:0] {
      VERDICT_NONE  = 2'd0,
      VERDICT_GRANT = 2'd1,
      VERDICT_DENY  = 2'd2
   } verdict_e;
endpackage

// File: rtl/wprot_lockbank.sv
module wprot_lockbank #(
   parameter int   NBLK_W   = 4,
   parameter logic LOCK_RST = 1'b1,
   localparam int  NBLK     = 1 << NBLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [NBLK_W-1:0] wsel,
   input  logic              wdata,
   input  logic [NBLK_W-1:0] rsel,
   output logic              rdata,
   output logic [NBLK-1:0]   lock_vec
);
   for (genvar gi = 0; gi < NBLK; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lock_vec[gi] <= LOCK_RST;
         else if (we && (wsel == NBLK_W'(gi)))
            lock_vec[gi] <= wdata;
      end
   end

   assign rdata = lock_vec[rsel];
endmodule

// File: rtl/wprot_decide.sv
module wprot_decide #(
   parameter int  ADDR_W   = 20,
   parameter int  NBLK_W   = 4,
   parameter int  BOOT_BLK = (1 << NBLK_W) - 1,
   localparam int NBLK     = 1 << NBLK_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBLK-1:0]   lock_vec,
   input  logic              boot_lock_n,
   input  logic              wr_prot_n,
   output logic              deny
);
   logic [NBLK-1:0]   prot_vec;
   logic [NBLK_W-1:0] blk;

   assign blk = addr[ADDR_W-1 -: NBLK_W];

   for (genvar gi = 0; gi < NBLK; gi++) begin : g_prot
      if (gi == BOOT_BLK) begin : g_boot
         assign prot_vec[gi] = lock_vec[gi] | ~boot_lock_n;
      end else begin : g_main
         assign prot_vec[gi] = lock_vec[gi] | ~wr_prot_n;
      end
   end

   assign deny = prot_vec[blk];
endmodule

// File: rtl/wprot_oplatch.sv
module wprot_oplatch
   import wprot_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_start,
   input  logic deny,
   output logic eng_start,
   output logic op_reject,
   output logic op_allowed
);
   verdict_e verdict_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q  <= VERDICT_NONE;
         op_allowed <= 1'b0;
      end else begin
         if (req_start) begin
            verdict_q  <= deny ? VERDICT_DENY : VERDICT_GRANT;
            op_allowed <= ~deny;
         end else begin
            verdict_q  <= VERDICT_NONE;
         end
      end
   end

   assign eng_start = (verdict_q == VERDICT_GRANT);
   assign op_reject = (verdict_q == VERDICT_DENY);
endmodule

// File: rtl/wprot_arbiter.sv
module wprot_arbiter #(
   parameter int   ADDR_W   = 20,
   parameter int   NBLK_W   = 4,
   parameter logic LOCK_RST = 1'b1,
   localparam int  NBLK     = 1 << NBLK_W,
   localparam int  BOOT_BLK = NBLK - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_lock_n,
   input  logic              wr_prot_n,
   input  logic              lock_we,
   input  logic [NBLK_W-1:0] lock_wsel,
   input  logic              lock_wdata,
   input  logic [NBLK_W-1:0] lock_rsel,
   output logic              lock_rdata,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              eng_start,
   output logic              op_reject,
   output logic              op_allowed
);
   if (NBLK_W < 1 || NBLK_W > ADDR_W) begin : g_bad_blk
      $error("wprot_arbiter: NBLK_W must lie in 1..ADDR_W");
   end
   if (NBLK_W > 8) begin : g_bad_size
      $error("wprot_arbiter: NBLK_W too large for a flat lock bank");
   end

   logic [NBLK-1:0] lock_vec;
   logic            deny;

   wprot_lockbank #(.NBLK_W(NBLK_W), .LOCK_RST(LOCK_RST)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (lock_we),
      .wsel     (lock_wsel),
      .wdata    (lock_wdata),
      .rsel     (lock_rsel),
      .rdata    (lock_rdata),
      .lock_vec (lock_vec)
   );

   wprot_decide #(.ADDR_W(ADDR_W), .NBLK_W(NBLK_W), .BOOT_BLK(BOOT_BLK)) u_dec (
      .addr        (req_addr),
      .lock_vec    (lock_vec),
      .boot_lock_n (boot_lock_n),
      .wr_prot_n   (wr_prot_n),
      .deny        (deny)
   );

   wprot_oplatch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_start  (req_start),
      .deny       (deny),
      .eng_start  (eng_start),
      .op_reject  (op_reject),
      .op_allowed (op_allowed)
   );
endmodule

// File: rtl/wprot_arbiter_chk.sv
module wprot_arbiter_chk #(
   parameter int ADDR_W = 20,
   parameter int NBLK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boot_lock_n,
   input logic              wr_prot_n,
   input logic              lock_we,
   input logic [NBLK_W-1:0] lock_wsel,
   input logic              lock_wdata,
   input logic [NBLK_W-1:0] lock_rsel,
   input logic              lock_rdata,
   input logic              req_start,
   input logic [ADDR_W-1:0] req_addr,
   input logic              eng_start,
   input logic              op_reject,
   input logic              op_allowed
);
   localparam logic [NBLK_W-1:0] BOOT = {NBLK_W{1'b1}};

   logic [NBLK_W-1:0] req_blk;
   assign req_blk = req_addr[ADDR_W-1 -: NBLK_W];

   // R9
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start && op_reject));

   // R9
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start || op_reject) |-> $past(req_start));

   // R9
   verdict_given_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_start |=> (eng_start || op_reject));

   // R4
   boot_pin_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !boot_lock_n && req_blk == BOOT) |=> op_reject);

   // R6
   wp_pin_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !wr_prot_n && req_blk != BOOT) |=> op_reject);

   // R10
   allow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_start |=> $stable(op_allowed));

   // R10
   allow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_start |=> (op_allowed == eng_start));

   // R2
   lock_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_we && lock_rsel == lock_wsel) |=>
         (!$stable(lock_rsel) || lock_rdata == $past(lock_wdata)));
endmodule

bind wprot_arbiter wprot_arbiter_chk #(.ADDR_W(ADDR_W), .NBLK_W(NBLK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .boot_lock_n (boot_lock_n),
   .wr_prot_n   (wr_prot_n),
   .lock_we     (lock_we),
   .lock_wsel   (lock_wsel),
   .lock_wdata  (lock_wdata),
   .lock_rsel   (lock_rsel),
   .lock_rdata  (lock_rdata),
   .req_start   (req_start),
   .req_addr    (req_addr),
   .eng_start   (eng_start),
   .op_reject   (op_reject),
   .op_allowed  (op_allowed)
);

// File: tb/wprot_arbiter_bench.sv
`timescale 1ns/1ps
module wprot_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_lock_n = 1'b1;
   logic        wr_prot_n = 1'b1;
   logic        lock_we = 1'b0;
   logic [3:0]  lock_wsel = '0;
   logic        lock_wdata = 1'b0;
   logic [3:0]  lock_rsel = '0;
   logic        lock_rdata;
   logic        req_start = 1'b0;
   logic [19:0] req_addr = '0;
   logic        eng_start, op_reject, op_allowed;

   int vectors = 0;
   int misses  = 0;

   // behavioural reference state
   bit m_lock [16];
   bit m_start, m_rej, m_ok;

   always #2.5 clk = ~clk;

   wprot_arbiter u_wprot_arbiter (
      .clk(clk), .rst_n(rst_n), .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n),
      .lock_we(lock_we), .lock_wsel(lock_wsel), .lock_wdata(lock_wdata),
      .lock_rsel(lock_rsel), .lock_rdata(lock_rdata), .req_start(req_start),
      .req_addr(req_addr), .eng_start(eng_start), .op_reject(op_reject),
      .op_allowed(op_allowed)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_lock[i]) m_lock[i] = 1'b1;
         m_start = 0; m_rej = 0; m_ok = 0;
      end else begin
         m_start = 0; m_rej = 0;
         if (req_start) begin
            int  blk;
            bit  locked;
            blk = int'(req_addr) / 65536;
            if (blk == 15) locked = m_lock[15] || (boot_lock_n == 1'b0);
            else           locked = m_lock[blk] || (wr_prot_n == 1'b0);
            m_ok = !locked; m_start = !locked; m_rej = locked;
         end
         if (lock_we) m_lock[int'(lock_wsel)] = lock_wdata;
      end
   end

   task automatic cmp1(input string tag, input string what, input logic act, input bit exp);
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // apply current inputs for one clock, then compare at the falling edge
   task automatic cyc(input string tag);
      @(posedge clk);
      @(negedge clk);
      vectors++;
      cmp1(tag, "eng_start",  eng_start,  m_start);
      cmp1(tag, "op_reject",  op_reject,  m_rej);
      cmp1(tag, "op_allowed", op_allowed, m_ok);
      cmp1(tag, "lock_rdata", lock_rdata, m_lock[int'(lock_rsel)]);
      req_start = 0; lock_we = 0;
   endtask

   task automatic wr_lock(input int blk, input bit v, input string tag);
      lock_we = 1; lock_wsel = 4'(blk); lock_wdata = v; lock_rsel = 4'(blk);
      cyc(tag);
      cyc(tag);
   endtask

   task automatic req(input logic [19:0] a, input string tag);
      req_start = 1; req_addr = a;
      cyc(tag);
      cyc(tag);
   endtask

   initial begin
      #200000;
      misses++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc("R1_reset");
      cyc("R1_reset");
      rst_n = 1;
      for (int i = 0; i < 16; i++) begin
         lock_rsel = 4'(i);
         cyc("R1_locks");
      end
      // R6: locked block, pin high -> reject
      req(20'h3_1234, "R6_locked");
      wr_lock(3, 0, "R2_clear");
      req(20'h3_0000, "R6_unlocked");
      // R10: hold with no strobe while pins/locks change
      wr_prot_n = 0; cyc("R10_hold"); cyc("R10_hold");
      wr_lock(3, 1, "R10_hold");
      wr_lock(3, 0, "R2_clear");
      // R6/R7: wp low rejects block 3; boot pin irrelevant
      boot_lock_n = 1; req(20'h3_FFFF, "R6_pin");
      wr_prot_n = 1; boot_lock_n = 0;
      req(20'h3_8000, "R7_bootpin_no_effect");
      // R8/R4: clear boot lock while boot pin low
      wr_lock(15, 0, "R8_readback");
      req(20'hF_0000, "R4_R8_still_denied");
      // R5
      boot_lock_n = 1;
      req(20'hF_FFFF, "R5_grant");
      // R7: wp low does not touch boot block
      wr_prot_n = 0;
      req(20'hF_0100, "R7_wp_no_effect");
      wr_prot_n = 1;
      wr_lock(15, 1, "R2_set");
      req(20'hF_0000, "R5_deny");
      // R3: boundary block 14 vs 15
      wr_lock(14, 0, "R2_clear");
      boot_lock_n = 0;
      req(20'hE_FFFF, "R3_blk14");
      req(20'hF_0000, "R3_blk15");
      boot_lock_n = 1;
      // R11: lock write coincident with strobe
      req_start = 1; req_addr = 20'h3_0004;
      lock_we = 1; lock_wsel = 4'd3; lock_wdata = 1; lock_rsel = 4'd3;
      cyc("R11_old_value");
      cyc("R11_old_value");
      req(20'h3_0004, "R11_new_value");
      // back-to-back strobes (R9)
      req_start = 1; req_addr = 20'hE_0000; cyc("R9_b2b");
      req_start = 1; req_addr = 20'h3_0000; cyc("R9_b2b");
      cyc("R9_b2b");
      // walk all blocks with pins high: grants only where cleared
      for (int b = 0; b < 16; b++) begin
         req(20'(b * 65536 + 7), "R6_R5_walk");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule